// File: doc/BRIEF.md
# Dual-Clock FIFO with Gray-Coded Pointer Crossing

This block buffers words between two clock domains whose clocks have unrelated frequencies and phases. The producer pushes one word per write-clock edge while the buffer is not full, and the consumer pops one word per read-clock edge while it is not empty. The storage is a dual-port memory. Each side addresses it with its own binary counter.

Only Gray-coded, registered copies of the two counters cross between the domains. Each copy is resynchronised in the destination domain and converted back to binary there. The read side subtracts its own counter from the converted write pointer to get an occupancy count and an empty flag. The write side mirrors that arithmetic to get a full flag. Both counters are one bit wider than the address, so a full buffer and an empty buffer give different results.

The read port shows the head word on its data output whenever the buffer is not empty. A pop advances to the next word on the following read edge. The occupancy output is combinational by default. It can be registered for one extra read cycle of latency.

Top module: `cdc_fifo`

## Requirements
- R1: After reset, empty_o is 1, full_o is 0 and rd_count_o is 0.
- R2: Words leave in the order they were accepted. Whenever empty_o is 0, rd_data_o holds the oldest unread word.
- R3: A write attempted while full_o is 1 is dropped. The stored contents and the write pointer are unchanged, and the buffer never holds more than 2^AW words.
- R4: A read attempted while empty_o is 1 is dropped. The read pointer does not move, and empty_o is never 0 unless an accepted word is still unread.
- R5: full_o is 0 while fewer than 2^AW words are stored. It becomes 1 once 2^AW words have been written and none read, and it returns to 0 after the buffer is drained.
- R6: rd_count_o never exceeds 2^AW or the true occupancy. Once both sides have been idle for a few read cycles, it equals the number of stored words.
- R7: With the default combinational count, empty_o is 1 exactly when rd_count_o is 0.
- R8: Pointer copies cross as Gray codes, and each copy changes by at most one bit per edge of its own clock. A write becomes visible on the read side within SYNC_STAGES+2 read-clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk_i | input | 1 | Write-domain clock |
| wr_rst_ni | input | 1 | Write-domain asynchronous reset, active low |
| wr_en_i | input | 1 | Push request |
| wr_data_i | input | DW | Word to push |
| full_o | output | 1 | Buffer full; pushes are dropped |
| rd_clk_i | input | 1 | Read-domain clock |
| rd_rst_ni | input | 1 | Read-domain asynchronous reset, active low |
| rd_en_i | input | 1 | Pop request |
| rd_data_o | output | DW | Oldest unread word, valid while empty_o is 0 |
| empty_o | output | 1 | Buffer empty; pops are dropped |
| rd_count_o | output | AW+1 | Occupancy seen from the read domain |

## Verification
The bench holds the write enable high for several cycles past the point where the buffer fills, then drains it. A design that let a blocked write through would wrap its pointer and return either too many words or overwritten words. It also pulses the read enable on an empty buffer and then checks that a single later word is still read back. An underflowing read pointer would hide that word or repeat stale data. Random traffic with the write clock both faster and slower than the read clock compares every popped word against a reference queue. It also flags any moment where empty_o drops with nothing unread or full_o stays low with the buffer full. A broken Gray conversion or a wrong subtraction would show up as phantom data, lost words or a count that never settles.

// File: rtl/cdc_fifo_pkg.sv
`timescale 1ns/1ps
package cdc_fifo_pkg;

  // Zero-extended operands make these valid for any width up to 32.
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = g[i] ^ b[i+1];
    return b;
  endfunction

endpackage

// File: rtl/fifo_sync.sv
`timescale 1ns/1ps
module fifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  // First stage captures the remote register directly, no logic in between.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/fifo_mem.sv
`timescale 1ns/1ps
module fifo_mem #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          wr_clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wr_clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fifo_wr_ctrl.sv
`timescale 1ns/1ps
module fifo_wr_ctrl
  import cdc_fifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW:0]   rd_gray_sync_i,
  output logic          fire_o,
  output logic [AW-1:0] addr_o,
  output logic [AW:0]   ptr_o,
  output logic [AW:0]   gray_o,
  output logic          full_o
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] ptr_q, ptr_d, gray_q, gray_d, rd_bin, used;

  assign rd_bin = PW'(gray2bin(32'(rd_gray_sync_i)));
  assign used   = ptr_q - rd_bin;
  assign full_o = (used == PW'(DEPTH));
  assign fire_o = wr_en_i & ~full_o;

  // Gray copy is fed from the counter's next value, so both update on one edge.
  assign ptr_d  = ptr_q + PW'(fire_o);
  assign gray_d = PW'(bin2gray(32'(ptr_d)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      gray_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      gray_q <= gray_d;
    end
  end

  assign addr_o = ptr_q[AW-1:0];
  assign ptr_o  = ptr_q;
  assign gray_o = gray_q;
endmodule

// File: rtl/fifo_rd_ctrl.sv
`timescale 1ns/1ps
module fifo_rd_ctrl
  import cdc_fifo_pkg::*;
#(
  parameter int AW        = 4,
  parameter bit REG_COUNT = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [AW:0]   wr_gray_sync_i,
  output logic [AW-1:0] addr_o,
  output logic [AW:0]   ptr_o,
  output logic [AW:0]   gray_o,
  output logic          empty_o,
  output logic [AW:0]   count_o
);
  localparam int PW = AW + 1;

  logic [PW-1:0] ptr_q, ptr_d, gray_q, gray_d, wr_bin, count_c;
  logic          fire;

  assign wr_bin  = PW'(gray2bin(32'(wr_gray_sync_i)));
  assign count_c = wr_bin - ptr_q;
  assign empty_o = (count_c == '0);
  assign fire    = rd_en_i & ~empty_o;

  assign ptr_d  = ptr_q + PW'(fire);
  assign gray_d = PW'(bin2gray(32'(ptr_d)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      gray_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      gray_q <= gray_d;
    end
  end

  if (REG_COUNT) begin : g_cnt_reg
    logic [PW-1:0] count_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) count_q <= '0;
      else         count_q <= count_c;
    end
    assign count_o = count_q;
  end else begin : g_cnt_comb
    assign count_o = count_c;
  end

  assign addr_o = ptr_q[AW-1:0];
  assign ptr_o  = ptr_q;
  assign gray_o = gray_q;
endmodule

// File: rtl/cdc_fifo.sv
`timescale 1ns/1ps
module cdc_fifo #(
  parameter int DW          = 8,
  parameter int AW          = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit REG_COUNT   = 1'b0
) (
  input  logic          wr_clk_i,
  input  logic          wr_rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          full_o,
  input  logic          rd_clk_i,
  input  logic          rd_rst_ni,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          empty_o,
  output logic [AW:0]   rd_count_o
);
  localparam int PW = AW + 1;

  logic [AW-1:0] wr_addr, rd_addr;
  logic [PW-1:0] wr_ptr, wr_gray, rd_ptr, rd_gray;
  logic [PW-1:0] wr_gray_in_rd, rd_gray_in_wr;
  logic          wr_fire;

  fifo_wr_ctrl #(.AW(AW)) u_wr (
    .clk_i          (wr_clk_i),
    .rst_ni         (wr_rst_ni),
    .wr_en_i        (wr_en_i),
    .rd_gray_sync_i (rd_gray_in_wr),
    .fire_o         (wr_fire),
    .addr_o         (wr_addr),
    .ptr_o          (wr_ptr),
    .gray_o         (wr_gray),
    .full_o         (full_o)
  );

  fifo_rd_ctrl #(.AW(AW), .REG_COUNT(REG_COUNT)) u_rd (
    .clk_i          (rd_clk_i),
    .rst_ni         (rd_rst_ni),
    .rd_en_i        (rd_en_i),
    .wr_gray_sync_i (wr_gray_in_rd),
    .addr_o         (rd_addr),
    .ptr_o          (rd_ptr),
    .gray_o         (rd_gray),
    .empty_o        (empty_o),
    .count_o        (rd_count_o)
  );

  fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk_i  (rd_clk_i),
    .rst_ni (rd_rst_ni),
    .d_i    (wr_gray),
    .q_o    (wr_gray_in_rd)
  );

  fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk_i  (wr_clk_i),
    .rst_ni (wr_rst_ni),
    .d_i    (rd_gray),
    .q_o    (rd_gray_in_wr)
  );

  fifo_mem #(.AW(AW), .DW(DW)) u_mem (
    .wr_clk_i (wr_clk_i),
    .we_i     (wr_fire),
    .waddr_i  (wr_addr),
    .wdata_i  (wr_data_i),
    .raddr_i  (rd_addr),
    .rdata_o  (rd_data_o)
  );
endmodule

// File: rtl/cdc_fifo_chk.sv
`timescale 1ns/1ps
module cdc_fifo_chk
  import cdc_fifo_pkg::*;
#(
  parameter int AW        = 4,
  parameter bit REG_COUNT = 1'b0
) (
  input logic        wr_clk_i,
  input logic        wr_rst_ni,
  input logic        full_o,
  input logic [AW:0] wr_ptr,
  input logic [AW:0] wr_gray,
  input logic        rd_clk_i,
  input logic        rd_rst_ni,
  input logic        empty_o,
  input logic [AW:0] rd_ptr,
  input logic [AW:0] rd_gray,
  input logic [AW:0] rd_count_o
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  assert_no_overflow_R3: assert property (@(posedge wr_clk_i) disable iff (!wr_rst_ni)
    full_o |=> $stable(wr_ptr));

  assert_wr_step_R3: assert property (@(posedge wr_clk_i) disable iff (!wr_rst_ni)
    !$stable(wr_ptr) |-> wr_ptr == PW'($past(wr_ptr) + 1'b1));

  assert_no_underflow_R4: assert property (@(posedge rd_clk_i) disable iff (!rd_rst_ni)
    empty_o |=> $stable(rd_ptr));

  assert_count_bound_R6: assert property (@(posedge rd_clk_i) disable iff (!rd_rst_ni)
    rd_count_o <= PW'(DEPTH));

  assert_wr_gray_step_R8: assert property (@(posedge wr_clk_i) disable iff (!wr_rst_ni)
    !$stable(wr_gray) |-> $countones(wr_gray ^ $past(wr_gray)) == 1);

  assert_rd_gray_step_R8: assert property (@(posedge rd_clk_i) disable iff (!rd_rst_ni)
    !$stable(rd_gray) |-> $countones(rd_gray ^ $past(rd_gray)) == 1);

  assert_wr_gray_track_R8: assert property (@(posedge wr_clk_i) disable iff (!wr_rst_ni)
    wr_gray == PW'(bin2gray(32'(wr_ptr))));

  if (!REG_COUNT) begin : g_comb_chk
    assert_empty_count_R7: assert property (@(posedge rd_clk_i) disable iff (!rd_rst_ni)
      empty_o == (rd_count_o == '0));
  end
endmodule

bind cdc_fifo cdc_fifo_chk #(.AW(AW), .REG_COUNT(REG_COUNT)) u_chk (
  .wr_clk_i   (wr_clk_i),
  .wr_rst_ni  (wr_rst_ni),
  .full_o     (full_o),
  .wr_ptr     (wr_ptr),
  .wr_gray    (wr_gray),
  .rd_clk_i   (rd_clk_i),
  .rd_rst_ni  (rd_rst_ni),
  .empty_o    (empty_o),
  .rd_ptr     (rd_ptr),
  .rd_gray    (rd_gray),
  .rd_count_o (rd_count_o)
);

// File: tb/cdc_fifo_tb.sv
`timescale 1ns/1ps
module cdc_fifo_tb;
  localparam int CLK_PERIOD  = 10;
  localparam int DW          = 8;
  localparam int AW          = 4;
  localparam int SYNC_STAGES = 2;
  localparam int DEPTH       = 1 << AW;
  localparam int WATCHDOG_NS = 1000000;

  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          full, empty;
  logic [DW-1:0] rd_data;
  logic [AW:0]   rd_count;

  int wr_half = CLK_PERIOD / 2;
  int rd_half = CLK_PERIOD / 2 + 2;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] model_q [$];

  cdc_fifo #(.DW(DW), .AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_dut (
    .wr_clk_i   (wr_clk),
    .wr_rst_ni  (wr_rst_n),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .full_o     (full),
    .rd_clk_i   (rd_clk),
    .rd_rst_ni  (rd_rst_n),
    .rd_en_i    (rd_en),
    .rd_data_o  (rd_data),
    .empty_o    (empty),
    .rd_count_o (rd_count)
  );

  initial forever #(wr_half) wr_clk = ~wr_clk;
  initial forever #(rd_half) rd_clk = ~rd_clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Read-side observation, taken at a falling read edge before any pop decision.
  task automatic rd_observe();
    if (!empty) begin
      chk(model_q.size() > 0, "R4 empty low with nothing unread", model_q.size(), 1);
      if (model_q.size() > 0)
        chk(rd_data == model_q[0], "R2 data order", rd_data, model_q[0]);
    end
    chk(int'(rd_count) <= model_q.size(), "R6 count above occupancy", rd_count, model_q.size());
    chk(empty == (rd_count == '0), "R7 empty vs count", empty, rd_count == '0);
  endtask

  task automatic wr_observe();
    chk(model_q.size() <= DEPTH, "R3 occupancy bound", model_q.size(), DEPTH);
    if (!full)
      chk(model_q.size() < DEPTH, "R3 full low while full", model_q.size(), DEPTH - 1);
  endtask

  task automatic run_writer(input int n, input int pct);
    int sent = 0;
    while (sent < n) begin
      @(negedge wr_clk);
      wr_observe();
      if ($urandom_range(99) < pct) begin
        wr_en   = 1'b1;
        wr_data = DW'($urandom);
        if (!full) begin
          model_q.push_back(wr_data);
          sent++;
        end
      end else wr_en = 1'b0;
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic run_reader(input int n, input int pct);
    int got = 0;
    while (got < n) begin
      @(negedge rd_clk);
      rd_observe();
      if ($urandom_range(99) < pct) begin
        rd_en = 1'b1;
        if (!empty) begin
          void'(model_q.pop_front());
          got++;
        end
      end else rd_en = 1'b0;
    end
    @(negedge rd_clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_wait(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk);
      rd_observe();
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(WATCHDOG_NS);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG_NS, 0);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 3);
    @(negedge wr_clk) wr_rst_n = 1'b1;
    @(negedge rd_clk) rd_rst_n = 1'b1;
    rd_wait(3);

    // R1 reset state
    chk(empty == 1'b1, "R1 empty after reset", empty, 1);
    chk(full == 1'b0, "R1 full after reset", full, 0);
    chk(rd_count == '0, "R1 count after reset", rd_count, 0);

    // R4 pops on an empty buffer are dropped
    for (int i = 0; i < 6; i++) begin
      @(negedge rd_clk);
      rd_observe();
      rd_en = 1'b1;
    end
    @(negedge rd_clk) rd_en = 1'b0;
    chk(empty == 1'b1, "R4 still empty", empty, 1);
    @(negedge wr_clk);
    wr_en = 1'b1; wr_data = 8'hA5;
    model_q.push_back(8'hA5);
    @(negedge wr_clk) wr_en = 1'b0;
    rd_wait(SYNC_STAGES + 2);
    chk(rd_count == 1, "R8 write visible in time", rd_count, 1);
    chk(rd_data == 8'hA5, "R4 pointer did not drift", rd_data, 8'hA5);
    @(negedge rd_clk);
    rd_en = 1'b1;
    void'(model_q.pop_front());
    @(negedge rd_clk) rd_en = 1'b0;
    rd_wait(4);
    chk(empty == 1'b1, "R7 empty after single pop", empty, 1);

    // R5 fill to the boundary and past it, no reads
    for (int i = 0; i < DEPTH + 4; i++) begin
      @(negedge wr_clk);
      if (i == DEPTH - 1) chk(full == 1'b0, "R5 full low one short", full, 0);
      wr_en = 1'b1; wr_data = DW'(i);
      if (!full) model_q.push_back(wr_data);
    end
    @(negedge wr_clk) wr_en = 1'b0;
    @(negedge wr_clk);
    chk(full == 1'b1, "R5 full at depth", full, 1);
    chk(model_q.size() == DEPTH, "R3 writes dropped while full", model_q.size(), DEPTH);
    rd_wait(SYNC_STAGES + 3);
    chk(rd_count == DEPTH, "R6 count at depth", rd_count, DEPTH);

    // drain, order checked in rd_observe
    while (model_q.size() > 0) begin
      @(negedge rd_clk);
      rd_observe();
      rd_en = 1'b1;
      if (!empty) void'(model_q.pop_front());
    end
    @(negedge rd_clk) rd_en = 1'b0;
    rd_wait(4);
    chk(empty == 1'b1, "R7 empty after drain", empty, 1);
    chk(rd_count == '0, "R6 count after drain", rd_count, 0);
    for (int i = 0; i < SYNC_STAGES + 3; i++) @(negedge wr_clk);
    chk(full == 1'b0, "R5 full released", full, 0);

    // random traffic, writer faster than reader
    wr_half = 3; rd_half = 11;
    fork
      run_writer(300, 70);
      run_reader(300, 50);
    join
    rd_wait(4);
    chk(empty == 1'b1 && model_q.size() == 0, "R2 phase A balanced", model_q.size(), 0);

    // random traffic, reader faster than writer
    wr_half = 13; rd_half = 4;
    fork
      run_writer(300, 90);
      run_reader(300, 40);
    join
    rd_wait(4);
    chk(empty == 1'b1 && model_q.size() == 0, "R2 phase B balanced", model_q.size(), 0);

    // near 1:1 with bursty reads
    wr_half = 5; rd_half = 6;
    fork
      run_writer(400, 95);
      run_reader(400, 30);
    join
    rd_wait(4);
    chk(rd_count == '0, "R6 count settles", rd_count, 0);

    done = 1'b1;
    finish_run();
  end
endmodule